// File: doc/BRIEF.md
# L2 Bank Lease Timestamp Tracker

This block holds the lease timestamps and the data words for the resident blocks of one L2 bank in a coherence scheme driven by a shared global clock. Each block keeps a single timestamp: the latest moment up to which any L1 may still hold a valid copy. The bank sends no invalidations and keeps no sharer lists. A block whose timestamp is below the current global time has no live L1 copies.

Requests arrive on one port with an operation, a block index, a requested lifetime and write data. Each request gets a registered response one cycle later.
- **Load:** extends the block's lease and returns the data with the new timestamp.
- **Store:** writes at once, without stalling. It returns a write completion time: the block's timestamp if the lease is still running, or the global time if the lease has expired.
- **Eviction:** clears the timestamp.
- **Probe:** reads the block without changing anything.

Every response also carries a live-copy flag and three event flags for a lifetime predictor.

Top module: `lease_tracker`

## Requirements
- R1: After reset the response is invalid, and every block holds timestamp 0 and data 0.
- R2: A request with `req_valid` high gives exactly one response with `rsp_valid` high on the next cycle. `rsp_valid` stays low when there was no request, and an idle cycle changes no block.
- R3: A load (op 1) sets the block's timestamp to the larger of its old timestamp and `gtime + req_life`. It returns that new timestamp and the block's stored data.
- R4: A load never lowers a timestamp. If the old timestamp exceeds `gtime + req_life`, it is kept and returned.
- R5: When `gtime + req_life` exceeds the largest timestamp value, the lease saturates to all ones.
- R6: A store (op 2) writes `req_wdata` into the block in the same cycle, whatever the lease state. It leaves the timestamp unchanged, echoes the written data in `rsp_data`, and later requests see the new data.
- R7: A store returns as its completion time the old timestamp when that timestamp is at or above `gtime`, and `gtime` otherwise.
- R8: `rsp_live` is 1 exactly when the block's timestamp before the request was at or above `gtime`. Equality counts as live.
- R9: `rsp_event` has the following bits, and at most one bit is set. All three are 0 for a probe and when `rsp_valid` is low.
  - bit 0 is set for a load whose old timestamp was below `gtime`.
  - bit 1 is set for a store to a live block.
  - bit 2 is set for an eviction of a live block.
- R10: An eviction (op 3) clears the timestamp to 0, returns the old timestamp in `rsp_ts`, and keeps the data.
- R11: A probe (op 0) returns the stored data and timestamp and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gtime | input | TS_W | Current global time |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 probe, 1 load, 2 store, 3 evict |
| req_addr | input | ADDR_W | Block index within the bank |
| req_life | input | LIFE_W | Requested lease lifetime (loads) |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Block data, or the written data for a store |
| rsp_ts | output | TS_W | Lease timestamp or write completion time |
| rsp_live | output | 1 | Block had live L1 copies before the request |
| rsp_event | output | 3 | Predictor events: expired load, live store, live eviction |

## Verification
A wrong stored timestamp cannot be seen on the cycle it is written. It appears on the next request to the same block as a wrong `rsp_ts`, a flipped `rsp_live` or a wrong event bit. The stimulus therefore follows every state-changing operation with a probe or load of the same block. Lost or misdirected store data shows up in the data returned by the next access to that block. Timestamp comparisons that are off by one show up only when `gtime` equals the stored timestamp, so that boundary is driven in both directions.

// File: rtl/lease_pkg.sv
package lease_pkg;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_EVICT = 2'd3
    } lease_op_e;

    localparam int EV_W          = 3;
    localparam int EV_EXP_LOAD   = 0;
    localparam int EV_LIVE_STORE = 1;
    localparam int EV_LIVE_EVICT = 2;

endpackage

// File: rtl/lease_calc.sv
module lease_calc
    import lease_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int LIFE_W = 8
) (
    input  lease_op_e         op,
    input  logic [TS_W-1:0]   old_ts,
    input  logic [TS_W-1:0]   gtime,
    input  logic [LIFE_W-1:0] life,
    output logic              ts_we,
    output logic [TS_W-1:0]   new_ts,
    output logic [TS_W-1:0]   out_ts,
    output logic              live,
    output logic [EV_W-1:0]   events
);
    localparam int SUM_W = TS_W + 1;

    logic [SUM_W-1:0] sum;
    logic [TS_W-1:0]  target;

    always_comb begin
        sum    = {1'b0, gtime} + {{(SUM_W-LIFE_W){1'b0}}, life};
        target = sum[TS_W] ? {TS_W{1'b1}} : sum[TS_W-1:0];
        live   = (old_ts >= gtime);
        ts_we  = 1'b0;
        new_ts = old_ts;
        out_ts = old_ts;
        events = '0;
        case (op)
            OP_LOAD: begin
                ts_we  = 1'b1;
                new_ts = (old_ts > target) ? old_ts : target;
                out_ts = new_ts;
                events[EV_EXP_LOAD] = !live;
            end
            OP_STORE: begin
                out_ts = live ? old_ts : gtime;
                events[EV_LIVE_STORE] = live;
            end
            OP_EVICT: begin
                ts_we  = 1'b1;
                new_ts = '0;
                events[EV_LIVE_EVICT] = live;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lease_store.sv
module lease_store #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (we && waddr == AW'(g)) ent_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) ent_q[g] <= '0;
            else     ent_q[g] <= ent_d;
        end
    end

    assign rdata = ent_q[raddr];
endmodule

// File: rtl/lease_tracker.sv
module lease_tracker
    import lease_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int TS_W       = 16,
    parameter int LIFE_W     = 8,
    parameter int DATA_W     = 32,
    localparam int ADDR_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TS_W-1:0]        gtime,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [LIFE_W-1:0]      req_life,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic [TS_W-1:0]        rsp_ts,
    output logic                   rsp_live,
    output logic [2:0]             rsp_event
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   ts;
        logic              live;
        logic [EV_W-1:0]   ev;
    } rsp_t;

    rsp_t state_d, state_q;

    lease_op_e         op;
    logic [TS_W-1:0]   old_ts, new_ts, out_ts;
    logic [DATA_W-1:0] cur_data;
    logic              calc_we, live;
    logic [EV_W-1:0]   events;
    logic              ts_we, data_we;

    assign op      = lease_op_e'(req_op);
    assign ts_we   = req_valid && calc_we;
    assign data_we = req_valid && (op == OP_STORE);

    lease_store #(.DEPTH(NUM_BLOCKS), .W(TS_W)) i_ts (
        .clk(clk), .rst(rst), .we(ts_we), .waddr(req_addr),
        .wdata(new_ts), .raddr(req_addr), .rdata(old_ts)
    );

    lease_store #(.DEPTH(NUM_BLOCKS), .W(DATA_W)) i_data (
        .clk(clk), .rst(rst), .we(data_we), .waddr(req_addr),
        .wdata(req_wdata), .raddr(req_addr), .rdata(cur_data)
    );

    lease_calc #(.TS_W(TS_W), .LIFE_W(LIFE_W)) i_calc (
        .op(op), .old_ts(old_ts), .gtime(gtime), .life(req_life),
        .ts_we(calc_we), .new_ts(new_ts), .out_ts(out_ts),
        .live(live), .events(events)
    );

    always_comb begin
        state_d = '0;
        if (req_valid) begin
            state_d.valid = 1'b1;
            state_d.data  = (op == OP_STORE) ? req_wdata : cur_data;
            state_d.ts    = out_ts;
            state_d.live  = live;
            state_d.ev    = events;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rsp_valid = state_q.valid;
    assign rsp_data  = state_q.data;
    assign rsp_ts    = state_q.ts;
    assign rsp_live  = state_q.live;
    assign rsp_event = state_q.ev;
endmodule

// File: rtl/lease_tracker_chk.sv
module lease_tracker_chk #(
    parameter int TS_W   = 16,
    parameter int LIFE_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [TS_W-1:0]   gtime,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LIFE_W-1:0] req_life,
    input logic              rsp_valid,
    input logic [TS_W-1:0]   rsp_ts,
    input logic              rsp_live,
    input logic [2:0]        rsp_event
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_load_covers_now_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1) |=> (rsp_ts >= $past(gtime)));

    assert_store_wct_not_past_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |=> (rsp_ts >= $past(gtime)));

    assert_events_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_event));

    assert_events_need_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_event != 3'b000) |-> rsp_valid);

    assert_expired_not_live_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_event[0] |-> !rsp_live);

    assert_live_events_live_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_event[1] || rsp_event[2]) |-> rsp_live);

    assert_probe_no_event_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0) |=> (rsp_event == 3'b000));
endmodule

bind lease_tracker lease_tracker_chk #(
    .TS_W(TS_W), .LIFE_W(LIFE_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst(rst), .gtime(gtime), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_life(req_life),
    .rsp_valid(rsp_valid), .rsp_ts(rsp_ts), .rsp_live(rsp_live),
    .rsp_event(rsp_event)
);

// File: tb/test_lease_tracker.sv
module test_lease_tracker;
    localparam int TS_W = 16, LIFE_W = 8, DATA_W = 32, NB = 16, AW = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [TS_W-1:0]   gtime;
    logic              req_valid;
    logic [1:0]        req_op;
    logic [AW-1:0]     req_addr;
    logic [LIFE_W-1:0] req_life;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [TS_W-1:0]   rsp_ts;
    logic              rsp_live;
    logic [2:0]        rsp_event;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lease_tracker #(.NUM_BLOCKS(NB), .TS_W(TS_W), .LIFE_W(LIFE_W), .DATA_W(DATA_W)) i_lease_tracker (
        .clk(clk), .rst(rst), .gtime(gtime), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_life(req_life),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_ts(rsp_ts), .rsp_live(rsp_live), .rsp_event(rsp_event)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [7:0]  life;
        logic [31:0] wdata;
        logic [15:0] gt;
        logic [31:0] edata;
        logic [15:0] ets;
        logic        elive;
        logic [2:0]  eev;
    } vec_t;

    // op: 0 probe, 1 load, 2 store, 3 evict
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 4'd3,  8'd0,   32'h0,    16'd5,      32'h0,    16'd5,      1'b0, 3'b001}, // R1 R3 R9
        '{2'd1, 4'd3,  8'd10,  32'h0,    16'd6,      32'h0,    16'd16,     1'b0, 3'b001}, // R3
        '{2'd1, 4'd3,  8'd2,   32'h0,    16'd8,      32'h0,    16'd16,     1'b1, 3'b000}, // R4
        '{2'd2, 4'd3,  8'd0,   32'hAA,   16'd9,      32'hAA,   16'd16,     1'b1, 3'b010}, // R6 R7
        '{2'd0, 4'd3,  8'd0,   32'h0,    16'd9,      32'hAA,   16'd16,     1'b1, 3'b000}, // R11 R6
        '{2'd2, 4'd7,  8'd0,   32'h55,   16'd20,     32'h55,   16'd20,     1'b0, 3'b000}, // R7
        '{2'd0, 4'd7,  8'd0,   32'h0,    16'd20,     32'h55,   16'd0,      1'b0, 3'b000}, // R6
        '{2'd3, 4'd3,  8'd0,   32'h0,    16'd16,     32'hAA,   16'd16,     1'b1, 3'b100}, // R10
        '{2'd0, 4'd3,  8'd0,   32'h0,    16'd16,     32'hAA,   16'd0,      1'b0, 3'b000}, // R10
        '{2'd1, 4'd7,  8'd200, 32'h0,    16'hFFF0,   32'h55,   16'hFFFF,   1'b0, 3'b001}, // R5
        '{2'd3, 4'd7,  8'd0,   32'h0,    16'hFFF0,   32'h55,   16'hFFFF,   1'b1, 3'b100}, // R5 R10
        '{2'd3, 4'd9,  8'd0,   32'h0,    16'd3,      32'h0,    16'd0,      1'b0, 3'b000}, // R9
        '{2'd1, 4'd15, 8'd0,   32'h0,    16'd100,    32'h0,    16'd100,    1'b0, 3'b001}, // R3
        '{2'd0, 4'd15, 8'd0,   32'h0,    16'd100,    32'h0,    16'd100,    1'b1, 3'b000}, // R8
        '{2'd0, 4'd15, 8'd0,   32'h0,    16'd101,    32'h0,    16'd100,    1'b0, 3'b000}  // R8
    };

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] a, input logic [7:0] l,
                         input logic [31:0] wd, input logic [15:0] g);
        req_valid = 1'b1; req_op = op; req_addr = a; req_life = l; req_wdata = wd; gtime = g;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
        req_life = '0; req_wdata = '0; gtime = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1", "rsp_event after reset", 32'(rsp_event), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].addr, VEC[i].life, VEC[i].wdata, VEC[i].gt);
            check("R2", $sformatf("vec %0d valid", i), 32'(rsp_valid), 32'd1);
            check("R3/R6", $sformatf("vec %0d data", i), rsp_data, VEC[i].edata);
            check("R3/R7", $sformatf("vec %0d ts", i), 32'(rsp_ts), 32'(VEC[i].ets));
            check("R8", $sformatf("vec %0d live", i), 32'(rsp_live), 32'(VEC[i].elive));
            check("R9", $sformatf("vec %0d events", i), 32'(rsp_event), 32'(VEC[i].eev));
        end

        // R2: idle cycle gives no response and changes nothing
        gtime = 16'd50;
        @(negedge clk);
        check("R2", "no rsp when idle", 32'(rsp_valid), 32'd0);
        issue(2'd0, 4'd15, 8'd0, 32'h0, 16'd50);
        check("R2", "idle left ts", 32'(rsp_ts), 32'd100);

        // R6: store to a live block (gtime equal to ts) still writes at once
        issue(2'd2, 4'd15, 8'd0, 32'h1234, 16'd100);
        check("R6", "store echo", rsp_data, 32'h1234);
        check("R7", "store wct at boundary", 32'(rsp_ts), 32'd100);
        issue(2'd1, 4'd15, 8'd1, 32'h0, 16'd100);
        check("R6", "load sees stored data", rsp_data, 32'h1234);
        check("R3", "load extends", 32'(rsp_ts), 32'd101);

        // R1: reset mid-run clears all blocks
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "valid low after reset", 32'(rsp_valid), 32'd0);
        issue(2'd0, 4'd15, 8'd0, 32'h0, 16'd0);
        check("R1", "ts cleared", 32'(rsp_ts), 32'd0);
        check("R1", "data cleared", rsp_data, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule